// File: doc/BRIEF.md
# Configurable CRC-16 Frame Checker

This block runs a 16-bit cyclic redundancy check over byte-wide frames. Bytes enter one per cycle through a valid/ready handshake. Markers flag the first and last byte of each frame. The generator polynomial, the starting register value, the output XOR mask, the bit direction and a count of leading header bytes to leave out are all inputs. The block samples them once per frame, on the beat that opens the frame.

In check mode the last two bytes of a frame are the received checksum, high byte first. They are held back from the register and compared with the computed value. In generate mode every byte past the header feeds the register, and the result is the checksum to append before transmission. One cycle after the closing byte, the block presents a one-cycle completion strobe with the final CRC, and either a match flag or a short-frame error flag.

The package supplies a default profile: polynomial 0x1021, start 0xFFFF, output mask 0xFFFF, MSB-first, one header byte skipped. The output mask here is all ones, not the zero mask of the common CCITT setting. A second profile is also usable: polynomial 0x8005, start 0xFFFF, mask 0x0000, processed LSB-first.

Top module: `crc16_frame_chk`

## Requirements
- R1: While `rst` is high, `done`, `match`, `error` and `in_ready` are 0 and `crc_value` is 0. `in_ready` is 1 from the first clock edge after `rst` falls.
- R2: With the default profile, a frame made of header 0xD6, the ASCII bytes "123456789" and a two-byte trailer gives `crc_value` 0xD64E.
- R3: MSB-first update, for each data bit d taken from bit 7 down to bit 0: f = c[15]^d, then c = (c<<1) ^ (f ? poly : 0).
- R4: LSB-first update, for each data bit d taken from bit 0 up to bit 7: f = c[0]^d, then c = (c>>1) ^ (f ? bit-reversed poly : 0). With poly 0x8005, start 0xFFFF, mask 0x0000 and "123456789" (no header), the result is 0x4B37.
- R5: The first `cfg_skip` accepted bytes of a frame (0 to 15) do not enter the CRC.
- R6: In check mode the final two bytes form the received value {second-to-last, last}. They do not enter the register. `match` is 1 exactly when the received value equals the computed CRC XOR mask.
- R7: In check mode, a frame that has fewer than two bytes past the skipped header raises `error` with `match` at 0.
- R8: In generate mode (`cfg_gen_mode`=1), all bytes past the header enter the register. `crc_value` is the trailer to send, and `match` and `error` stay 0.
- R9: `done` is high for the single cycle after a beat carrying `in_eof` is accepted inside a frame. `crc_value` holds its value until the next `done`.
- R10: Configuration inputs are sampled only on the beat with `in_sof`. Changing them later in the frame has no effect on that frame.
- R11: Beats with `in_valid` low are ignored, and so are beats that arrive after a frame end but before the next `in_sof`.
- R12: `match` and `error` are never high together, and neither is high outside a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte beat offered |
| in_ready | output | 1 | Block accepts beats |
| in_data | input | 8 | Byte value |
| in_sof | input | 1 | Beat opens a frame |
| in_eof | input | 1 | Beat closes a frame |
| cfg_poly | input | 16 | Generator polynomial (normal form) |
| cfg_init | input | 16 | Register start value |
| cfg_xorout | input | 16 | Output XOR mask |
| cfg_lsb_first | input | 1 | 1: LSB-first processing |
| cfg_gen_mode | input | 1 | 1: generate trailer, 0: check trailer |
| cfg_skip | input | 4 | Header bytes left out of the CRC |
| done | output | 1 | One-cycle completion strobe |
| crc_value | output | 16 | Final CRC after the mask |
| match | output | 1 | Received trailer equals computed CRC |
| error | output | 1 | Frame too short to hold a trailer |

## Verification
The completion strobe of one frame can fall in the same cycle as the opening beat of the next. A frame can also open and close on a single beat. The bench provokes both with back-to-back single-byte generate frames: a new `in_sof`/`in_eof` beat is driven in the same cycle that `done` of the previous frame is visible. It then checks that each strobe carries its own frame's CRC, computed by an independent byte-wise reference model, and that the new frame's start value was not disturbed. The parameter sweeps also place the header skip, the trailer holdback and the end marker on the same beat, using short frames and zero-length payloads.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 16;

    localparam logic [CRC_W-1:0] DEF_POLY   = 16'h1021;
    localparam logic [CRC_W-1:0] DEF_INIT   = 16'hFFFF;
    localparam logic [CRC_W-1:0] DEF_XOROUT = 16'hFFFF;
    localparam logic [3:0]       DEF_SKIP   = 4'd1;

    // Settings that stay in force for the whole frame after its opening beat
    typedef struct packed {
        logic [CRC_W-1:0] poly;
        logic [CRC_W-1:0] xorout;
        logic             lsb_first;
        logic             gen_mode;
    } crc_run_t;

    function automatic logic [CRC_W-1:0] reflect16(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/crc16_byte_step.sv
module crc16_byte_step
    import crc16_pkg::*;
(
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] data,
    input  logic [CRC_W-1:0]  poly,
    input  logic              lsb_first,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] rpoly;
    logic [CRC_W-1:0] chain [0:BYTE_W];

    assign rpoly    = reflect16(poly);
    assign chain[0] = crc_in;

    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        logic             fb_m, fb_l;
        logic [CRC_W-1:0] nxt_m, nxt_l;
        assign fb_m  = chain[b][CRC_W-1] ^ data[BYTE_W-1-b];
        assign fb_l  = chain[b][0] ^ data[b];
        assign nxt_m = {chain[b][CRC_W-2:0], 1'b0} ^ (fb_m ? poly : '0);
        assign nxt_l = {1'b0, chain[b][CRC_W-1:1]} ^ (fb_l ? rpoly : '0);
        assign chain[b+1] = lsb_first ? nxt_l : nxt_m;
    end

    assign crc_out = chain[BYTE_W];
endmodule

// File: rtl/crc16_trailer_hold.sv
module crc16_trailer_hold
    import crc16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              push,
    input  logic [BYTE_W-1:0] din,
    output logic              evict,
    output logic [BYTE_W-1:0] evict_byte,
    output logic              full_next,
    output logic [CRC_W-1:0]  word_next
);
    logic [1:0]        cnt_q, cnt_eff, cnt_nx;
    logic [BYTE_W-1:0] old_q, new_q, old_eff, new_eff, old_nx, new_nx;

    always_comb begin
        cnt_eff = clear ? 2'd0 : cnt_q;
        old_eff = clear ? '0 : old_q;
        new_eff = clear ? '0 : new_q;
        cnt_nx  = cnt_eff;
        old_nx  = old_eff;
        new_nx  = new_eff;
        if (push) begin
            old_nx = new_eff;
            new_nx = din;
            cnt_nx = (cnt_eff == 2'd2) ? 2'd2 : cnt_eff + 2'd1;
        end
    end

    assign evict      = push && (cnt_eff == 2'd2);
    assign evict_byte = old_eff;
    assign full_next  = (cnt_nx == 2'd2);
    assign word_next  = {old_nx, new_nx};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= 2'd0;
            old_q <= '0;
            new_q <= '0;
        end else begin
            cnt_q <= cnt_nx;
            old_q <= old_nx;
            new_q <= new_nx;
        end
    end
endmodule

// File: rtl/crc16_frame_chk.sv
module crc16_frame_chk
    import crc16_pkg::*;
#(
    parameter int SKIP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [CRC_W-1:0]  cfg_poly,
    input  logic [CRC_W-1:0]  cfg_init,
    input  logic [CRC_W-1:0]  cfg_xorout,
    input  logic              cfg_lsb_first,
    input  logic              cfg_gen_mode,
    input  logic [SKIP_W-1:0] cfg_skip,
    output logic              done,
    output logic [CRC_W-1:0]  crc_value,
    output logic              match,
    output logic              error
);
    logic              ready_q;
    logic              in_frame_q;
    crc_run_t          run_q, run_live, run_eff;
    logic [CRC_W-1:0]  crc_q, crc_base, crc_next, crc_fin;
    logic [SKIP_W-1:0] skip_q, skip_base, skip_next;
    logic              beat, start, active, skipping;
    logic              push, evict, full_next;
    logic [BYTE_W-1:0] evict_byte, step_data;
    logic [CRC_W-1:0]  word_next, step_out;
    logic              step_en;

    assign in_ready = ready_q;
    assign beat     = in_valid && ready_q;
    assign start    = beat && in_sof;
    assign active   = start || (beat && in_frame_q);

    always_comb begin
        run_live.poly      = cfg_poly;
        run_live.xorout    = cfg_xorout;
        run_live.lsb_first = cfg_lsb_first;
        run_live.gen_mode  = cfg_gen_mode;
    end

    assign run_eff   = start ? run_live : run_q;
    assign crc_base  = start ? cfg_init : crc_q;
    assign skip_base = start ? cfg_skip : skip_q;
    assign skipping  = active && (skip_base != '0);
    assign skip_next = skipping ? skip_base - 1'b1 : skip_base;
    assign push      = active && !skipping && !run_eff.gen_mode;

    crc16_trailer_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .clear      (start),
        .push       (push),
        .din        (in_data),
        .evict      (evict),
        .evict_byte (evict_byte),
        .full_next  (full_next),
        .word_next  (word_next)
    );

    always_comb begin
        if (run_eff.gen_mode) begin
            step_en   = active && !skipping;
            step_data = in_data;
        end else begin
            step_en   = evict;
            step_data = evict_byte;
        end
    end

    crc16_byte_step u_step (
        .crc_in    (crc_base),
        .data      (step_data),
        .poly      (run_eff.poly),
        .lsb_first (run_eff.lsb_first),
        .crc_out   (step_out)
    );

    assign crc_next = step_en ? step_out : crc_base;
    assign crc_fin  = crc_next ^ run_eff.xorout;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q    <= 1'b0;
            in_frame_q <= 1'b0;
            run_q      <= '0;
            crc_q      <= '0;
            skip_q     <= '0;
            done       <= 1'b0;
            crc_value  <= '0;
            match      <= 1'b0;
            error      <= 1'b0;
        end else begin
            ready_q <= 1'b1;
            done    <= 1'b0;
            match   <= 1'b0;
            error   <= 1'b0;
            if (active) begin
                in_frame_q <= !in_eof;
                run_q      <= run_eff;
                crc_q      <= crc_next;
                skip_q     <= skip_next;
                if (in_eof) begin
                    done      <= 1'b1;
                    crc_value <= crc_fin;
                    if (!run_eff.gen_mode) begin
                        match <= full_next && (word_next == crc_fin);
                        error <= !full_next;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/crc16_frame_chk_sva.sv
module crc16_frame_chk_sva
    import crc16_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_eof,
    input logic             done,
    input logic [CRC_W-1:0] crc_value,
    input logic             match,
    input logic             error
);
    // R12
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(match && error));

    // R12
    flag_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (match || error) |-> done);

    // R9
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(in_valid && in_ready && in_eof));

    // R9
    value_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(crc_value));

    // R1
    ready_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> in_ready);
endmodule

bind crc16_frame_chk crc16_frame_chk_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_eof    (in_eof),
    .done      (done),
    .crc_value (crc_value),
    .match     (match),
    .error     (error)
);

// File: tb/test_crc16_frame_chk.sv
module test_crc16_frame_chk;
    import crc16_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic [15:0] cfg_poly = DEF_POLY, cfg_init = DEF_INIT, cfg_xorout = DEF_XOROUT;
    logic        cfg_lsb_first = 1'b0, cfg_gen_mode = 1'b0;
    logic [3:0]  cfg_skip = DEF_SKIP;
    logic        done, match, error;
    logic [15:0] crc_value;

    int errors = 0;
    int checks = 0;
    logic [7:0]  fb [0:39];
    logic [15:0] seed = 16'hACE1;
    bit          mid_chg = 1'b0;
    bit          gaps = 1'b0;

    always #10 clk = ~clk;

    crc16_frame_chk i_crc16_frame_chk (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .cfg_poly(cfg_poly), .cfg_init(cfg_init), .cfg_xorout(cfg_xorout),
        .cfg_lsb_first(cfg_lsb_first), .cfg_gen_mode(cfg_gen_mode),
        .cfg_skip(cfg_skip), .done(done), .crc_value(crc_value),
        .match(match), .error(error)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    function automatic logic [15:0] rev16(input logic [15:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = v[15-i];
        return r;
    endfunction

    // Byte-at-top reference; LSB-first done by mirroring data and register
    function automatic logic [15:0] ref_crc(input int first, input int n, input logic [15:0] poly,
                                            input logic [15:0] init, input logic [15:0] xo, input bit lsb);
        logic [15:0] r;
        logic [7:0]  d;
        r = lsb ? rev16(init) : init;
        for (int i = first; i < first + n; i++) begin
            d = lsb ? rev8(fb[i]) : fb[i];
            r = r ^ {d, 8'h00};
            for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ poly) : (r << 1);
        end
        return (lsb ? rev16(r) : r) ^ xo;
    endfunction

    function automatic logic [7:0] next_byte();
        seed = {seed[14:0], seed[15] ^ seed[13] ^ seed[12] ^ seed[10]};
        return seed[7:0] ^ seed[15:8];
    endfunction

    task automatic send(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = fb[i]; in_sof = (i == 0); in_eof = (i == n - 1);
            if (mid_chg && i == 1) begin
                cfg_poly = 16'h3D65; cfg_init = 16'h0000; cfg_xorout = 16'h1234;
                cfg_skip = 4'd0; cfg_lsb_first = ~cfg_lsb_first; cfg_gen_mode = ~cfg_gen_mode;
            end
            if (gaps && i != n - 1) begin
                @(negedge clk);
                in_valid = 1'b0; in_data = 8'hA5; in_sof = 1'b0; in_eof = 1'b1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic set_cfg(input int prof, input int skip, input bit lsb, input bit gen);
        cfg_poly   = (prof == 0) ? 16'h1021 : 16'h8005;
        cfg_init   = 16'hFFFF;
        cfg_xorout = (prof == 0) ? 16'hFFFF : 16'h0000;
        cfg_skip = skip[3:0]; cfg_lsb_first = lsb; cfg_gen_mode = gen;
    endtask

    // R3 R4 R5 R6 R8: one frame, checked against the reference model
    task automatic run_case(input int prof, input int skip, input bit lsb, input bit gen,
                            input int plen, input bit corrupt);
        logic [15:0] exp, tr, p, iv, xo;
        int n;
        set_cfg(prof, skip, lsb, gen);
        p = cfg_poly; iv = cfg_init; xo = cfg_xorout;
        for (int i = 0; i < skip; i++) fb[i] = next_byte();
        for (int i = 0; i < plen; i++) fb[skip + i] = next_byte();
        exp = ref_crc(skip, plen, p, iv, xo, lsb);
        n = skip + plen;
        if (!gen) begin
            tr = corrupt ? (exp ^ 16'h0100) : exp;
            fb[n] = tr[15:8]; fb[n+1] = tr[7:0];
            n = n + 2;
        end
        if (n == 0) return;
        send(n);
        chk("R9 done", {15'd0, done}, 16'd1);
        chk(lsb ? "R4 crc" : "R3 crc", crc_value, exp);
        if (gen) begin
            chk("R8 match", {15'd0, match}, 16'd0);
            chk("R8 error", {15'd0, error}, 16'd0);
        end else begin
            chk("R6 match", {15'd0, match}, {15'd0, !corrupt});
            chk("R5 error", {15'd0, error}, 16'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [15:0] exp_a, exp_b;
        repeat (3) @(negedge clk);
        chk("R1 done", {15'd0, done}, 16'd0);
        chk("R1 ready", {15'd0, in_ready}, 16'd0);
        chk("R1 crc", crc_value, 16'd0);
        chk("R1 flags", {14'd0, match, error}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 ready after", {15'd0, in_ready}, 16'd1);

        // R11: beats outside a frame and valid-low beats are ignored
        in_valid = 1'b1; in_eof = 1'b1; in_data = 8'h55;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R11 stray beat", {15'd0, done}, 16'd0);

        // R2: default profile known vector
        set_cfg(0, 1, 1'b0, 1'b0);
        fb[0] = 8'hD6;
        for (int i = 0; i < 9; i++) fb[1 + i] = 8'h31 + 8'(i);
        fb[10] = 8'hD6; fb[11] = 8'h4E;
        send(12);
        chk("R2 crc", crc_value, 16'hD64E);
        chk("R2 match", {15'd0, match}, 16'd1);

        // R4: reflected profile known vector, generate mode, no header
        set_cfg(1, 0, 1'b1, 1'b1);
        for (int i = 0; i < 9; i++) fb[i] = 8'h31 + 8'(i);
        send(9);
        chk("R4 vector", crc_value, 16'h4B37);

        // R11: valid-low gaps carrying eof inside the frame
        gaps = 1'b1;
        set_cfg(0, 1, 1'b0, 1'b0);
        fb[0] = 8'hD6;
        for (int i = 0; i < 9; i++) fb[1 + i] = 8'h31 + 8'(i);
        fb[10] = 8'hD6; fb[11] = 8'h4E;
        send(12);
        gaps = 1'b0;
        chk("R11 gaps crc", crc_value, 16'hD64E);
        chk("R11 gaps match", {15'd0, match}, 16'd1);

        // R10: configuration altered after the opening beat
        set_cfg(0, 1, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) fb[i] = next_byte();
        exp_a = ref_crc(1, 3, 16'h1021, 16'hFFFF, 16'hFFFF, 1'b0);
        fb[4] = exp_a[15:8]; fb[5] = exp_a[7:0];
        mid_chg = 1'b1;
        send(6);
        mid_chg = 1'b0;
        chk("R10 crc", crc_value, exp_a);
        chk("R10 match", {15'd0, match}, 16'd1);

        // R7: short frames
        set_cfg(0, 1, 1'b0, 1'b0);
        fb[0] = 8'hD6; fb[1] = 8'h12;
        send(2);
        chk("R7 error", {15'd0, error}, 16'd1);
        chk("R7 match", {15'd0, match}, 16'd0);
        set_cfg(1, 3, 1'b1, 1'b0);
        send(3);
        chk("R7 header only", {15'd0, error}, 16'd1);

        // R5: largest skip count leaves an empty CRC
        set_cfg(0, 15, 1'b0, 1'b1);
        for (int i = 0; i < 15; i++) fb[i] = next_byte();
        send(15);
        chk("R5 skip15", crc_value, 16'hFFFF ^ 16'hFFFF);

        // R9: back-to-back single-beat generate frames
        set_cfg(0, 0, 1'b0, 1'b1);
        fb[0] = 8'h3C; fb[1] = 8'hC3;
        exp_a = ref_crc(0, 1, 16'h1021, 16'hFFFF, 16'hFFFF, 1'b0);
        exp_b = ref_crc(1, 1, 16'h1021, 16'hFFFF, 16'hFFFF, 1'b0);
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_data = 8'h3C;
        @(negedge clk);
        chk("R9 first done", {15'd0, done}, 16'd1);
        chk("R9 first crc", crc_value, exp_a);
        in_data = 8'hC3;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        chk("R9 second done", {15'd0, done}, 16'd1);
        chk("R9 second crc", crc_value, exp_b);
        @(negedge clk);
        chk("R9 pulse ends", {15'd0, done}, 16'd0);
        chk("R9 crc held", crc_value, exp_b);
        chk("R12 flags idle", {14'd0, match, error}, 16'd0);

        // Sweep over profile, skip, order, mode and payload length
        for (int prof = 0; prof < 2; prof++)
            for (int sk = 0; sk < 4; sk++)
                for (int lsb = 0; lsb < 2; lsb++)
                    for (int gen = 0; gen < 2; gen++)
                        for (int pl = 0; pl < 6; pl++)
                            run_case(prof, sk, lsb[0], gen[0], pl, 1'b0);

        // R6: damaged trailers
        for (int sk = 0; sk < 3; sk++)
            for (int lsb = 0; lsb < 2; lsb++)
                run_case(sk % 2, sk, lsb[0], 1'b0, 3 + sk, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule